// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns a simple synchronous request port into the strobe sequence that an asynchronous, 8-bit-wide dynamic RAM expects. The RAM has an 11-bit multiplexed address bus. Each request carries a read/write flag, a 22-bit word address and write data. The controller splits the address into a row half and a column half. It opens the row with the row strobe, then runs one or more column cycles with the column strobe, and closes the row again. Writes use the early-write form: write enable goes low no later than the column strobe falls, so the RAM never drives the data pins. Reads capture the RAM data in the last clock of the column-strobe-low window and return it on `rd_data`, with a one-clock `rd_valid`.

A row stays open after a column cycle when the next request targets the same row. That request becomes a column-only cycle and no new row activation is needed. The row closes in three cases: the next request needs a different row, no request is waiting, or another column cycle would push the row-strobe-low time past its limit. A separate refresh block asks for the RAM through `ref_req`. The controller then finishes the current column cycle, closes the row, and reports through `ref_gnt` that the strobes are idle. Every timing interval is a parameter given in clock cycles. The defaults assume a 10 ns clock.

The request port follows valid/ready rules. A request is transferred on a clock edge where both `req_valid` and `req_ready` are high. The host must hold the request stable until then. `req_ready` is high only in the idle state, or in the final CAS-precharge cycle of an open row for a request whose row matches that row. While `ref_req` is high, `req_ready` is always low. There is no back-pressure on read data.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row half (`req_addr[21:11]`) is on `dram_addr` when `dram_ras_n` falls. The column half (`req_addr[10:0]`) is on `dram_addr` when `dram_cas_n` falls. Address and `dram_we_n` stay stable while `dram_cas_n` is low.
- R2: `dram_cas_n` falls no earlier than T_RCD cycles after `dram_ras_n` fell.
- R3: `dram_ras_n` stays low for at least T_RAS cycles, and stays high for at least T_RP cycles before it falls again.
- R4: `dram_cas_n` is low only while `dram_ras_n` is low. Between column cycles it stays high for at least T_CP cycles.
- R5: For a write, `dram_we_n` is low, `dram_oe_n` is high and `dram_dq_oe` is high (driving `dram_dq_out`) from the cycle in which `dram_cas_n` falls. The written byte is stored at the requested address.
- R6: For a read, `dram_we_n` is high, `dram_oe_n` is low and `dram_dq_oe` is low. The data is sampled in the last cycle of column-strobe-low. That window lasts at least T_CAS cycles, and on a row's first column it is long enough to satisfy T_RAC from the row-strobe fall. `rd_valid` is high for exactly one clock with the byte that was read.
- R7: A same-row request offered when the column precharge ends is served without raising `dram_ras_n`. A run of same-row requests therefore causes one row-strobe fall.
- R8: A request to a different row first closes the open row and waits out the row precharge. It then reopens the row strobe.
- R9: `dram_ras_n` never stays low for more than T_RASMAX consecutive cycles. A long same-row run is split into several row activations.
- R10: While `ref_req` is high, no new request is accepted, and an open row is closed after its current column cycle. `ref_gnt` is high exactly when the controller is idle with both strobes high and `ref_req` high.
- R11: After reset, all strobes are high, `dram_dq_oe` is low, `rd_valid` is low, and `req_ready` is high when `ref_req` is low.
- R12: A request is transferred only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a cycle or a precharge is in progress. Payload changes while `req_valid` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 8 | Read data |
| ref_req | input | 1 | Refresh block wants the RAM |
| ref_gnt | output | 1 | Strobes idle, RAM handed to refresh block |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data driven to the RAM |
| dram_dq_oe | output | 1 | Enable for the data-pin driver |
| dram_dq_in | input | 8 | Data returned from the RAM |

## Verification
The hardest situations to create from the ports are the two forced row closures: the row-strobe-low limit cutting a same-row run in two, and a refresh request arriving in the middle of a page burst. The bench builds the controller with a short T_RASMAX, so a burst of twenty back-to-back same-row writes must cross the limit. In a second test, the bench raises `ref_req` in a forked thread partway through a same-row read burst. The bench's RAM model returns a poison byte whenever the access time from either strobe has not yet passed. Random traffic is confined to four rows, so that page hits and row misses interleave, and any strobe shortcut shows up as a wrong read.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RCD  = 3'd1,
    S_CAS  = 3'd2,
    S_CPRE = 3'd3,
    S_HOLD = 3'd4,
    S_RP   = 3'd5
  } fpm_state_e;

  function automatic int fpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
  parameter int ROW_W    = 11,
  parameter int T_RAS    = 5,
  parameter int T_RASMAX = 10000,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_row,
  input  logic [ROW_W-1:0] req_row,
  input  logic             ras_n,
  output logic             hit,
  output logic             page_ok,
  output logic             ras_min_met
);
  localparam int PAGE_SPAN = T_CAS + T_CP + 1;
  localparam int CW = $clog2(T_RASMAX + 1) + 1;
  localparam logic [CW-1:0] PAGE_LIM = CW'(T_RASMAX - PAGE_SPAN);
  localparam logic [CW-1:0] MIN_LOW  = CW'(T_RAS - 1);

  logic [ROW_W-1:0] open_row;
  logic [CW-1:0]    low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_row <= '0;
      low_cnt  <= '0;
    end else begin
      if (acc_row) open_row <= req_row;
      if (ras_n) low_cnt <= '0;
      else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign hit         = (open_row == req_row);
  assign page_ok     = (low_cnt <= PAGE_LIM);
  assign ras_min_met = (low_cnt >= MIN_LOW);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int T_RCD       = 2,
  parameter int T_CAS       = 2,
  parameter int T_CAS_FIRST = 3,
  parameter int T_CP        = 1,
  parameter int T_RP        = 3,
  parameter int TMR_W       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic hit,
  input  logic page_ok,
  input  logic ras_min_met,
  input  logic ref_req,
  output logic req_ready,
  output logic ref_gnt,
  output logic acc_row,
  output logic acc_page,
  output logic go_first,
  output logic cap_rd,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic rd_valid
);
  fpm_state_e       state;
  logic [TMR_W-1:0] cnt;
  logic             wr_q;
  logic             idle_rdy, page_rdy, cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign idle_rdy  = (state == S_IDLE) && !ref_req;
  assign page_rdy  = (state == S_CPRE) && cnt_zero && hit && page_ok && !ref_req;
  assign req_ready = idle_rdy || page_rdy;
  assign acc_row   = req_valid && idle_rdy;
  assign acc_page  = req_valid && page_rdy;
  assign go_first  = (state == S_RCD) && cnt_zero;
  assign cap_rd    = (state == S_CAS) && cnt_zero && !wr_q;
  assign ref_gnt   = (state == S_IDLE) && ref_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_oe    <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap_rd;
      case (state)
        S_IDLE: begin
          if (acc_row) begin
            wr_q  <= req_write;
            ras_n <= 1'b0;
            cnt   <= TMR_W'(T_RCD - 1);
            state <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt_zero) begin
            cas_n <= 1'b0;
            we_n  <= !wr_q;
            oe_n  <= wr_q;
            dq_oe <= wr_q;
            cnt   <= TMR_W'(T_CAS_FIRST - 1);
            state <= S_CAS;
          end else cnt <= cnt - 1'b1;
        end
        S_CAS: begin
          if (cnt_zero) begin
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            cnt   <= TMR_W'(T_CP - 1);
            state <= S_CPRE;
          end else cnt <= cnt - 1'b1;
        end
        S_CPRE: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (acc_page) begin
            wr_q  <= req_write;
            cas_n <= 1'b0;
            we_n  <= !req_write;
            oe_n  <= req_write;
            dq_oe <= req_write;
            cnt   <= TMR_W'(T_CAS - 1);
            state <= S_CAS;
          end else if (ras_min_met) begin
            ras_n <= 1'b1;
            cnt   <= TMR_W'(T_RP - 1);
            state <= S_RP;
          end else state <= S_HOLD;
        end
        S_HOLD: begin
          if (ras_min_met) begin
            ras_n <= 1'b1;
            cnt   <= TMR_W'(T_RP - 1);
            state <= S_RP;
          end
        end
        S_RP: begin
          if (cnt_zero) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dpath.sv
module fpm_dpath #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 8,
  parameter int MA_W   = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_row,
  input  logic                   acc_page,
  input  logic                   go_first,
  input  logic                   cap_rd,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W-1:0]      dq_in,
  output logic [MA_W-1:0]        dram_addr,
  output logic [DATA_W-1:0]      dq_out,
  output logic [DATA_W-1:0]      rd_data
);
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q     <= '0;
      wd_q      <= '0;
      dram_addr <= '0;
      dq_out    <= '0;
      rd_data   <= '0;
    end else begin
      if (acc_row) begin
        dram_addr <= MA_W'(req_row);
        col_q     <= req_col;
        wd_q      <= req_wdata;
      end else if (go_first) begin
        dram_addr <= MA_W'(col_q);
        dq_out    <= wd_q;
      end else if (acc_page) begin
        dram_addr <= MA_W'(req_col);
        dq_out    <= req_wdata;
      end
      if (cap_rd) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int COL_W    = 11,
  parameter int DATA_W   = 8,
  parameter int T_RCD    = 2,
  parameter int T_RAC    = 5,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 1,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int T_RASMAX = 10000,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int T_CAS_FIRST = fpm_max(T_CAS, T_RAC - T_RCD);
  localparam int TMR_MAX = fpm_max(fpm_max(T_RCD, T_CAS_FIRST), fpm_max(T_CP, T_RP));
  localparam int TMR_W = $clog2(TMR_MAX + 1);

  logic hit, page_ok, ras_min_met;
  logic acc_row, acc_page, go_first, cap_rd;

  fpm_row_tracker #(
    .ROW_W(ROW_W), .T_RAS(T_RAS), .T_RASMAX(T_RASMAX), .T_CAS(T_CAS), .T_CP(T_CP)
  ) u_rows (
    .clk(clk), .rst_n(rst_n), .acc_row(acc_row),
    .req_row(req_addr[ADDR_W-1:COL_W]), .ras_n(dram_ras_n),
    .hit(hit), .page_ok(page_ok), .ras_min_met(ras_min_met)
  );

  fpm_seq #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CAS_FIRST(T_CAS_FIRST),
    .T_CP(T_CP), .T_RP(T_RP), .TMR_W(TMR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .hit(hit), .page_ok(page_ok), .ras_min_met(ras_min_met), .ref_req(ref_req),
    .req_ready(req_ready), .ref_gnt(ref_gnt), .acc_row(acc_row), .acc_page(acc_page),
    .go_first(go_first), .cap_rd(cap_rd), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .rd_valid(rd_valid)
  );

  fpm_dpath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .MA_W(MA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .acc_row(acc_row), .acc_page(acc_page),
    .go_first(go_first), .cap_rd(cap_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .dq_in(dram_dq_in), .dram_addr(dram_addr), .dq_out(dram_dq_out), .rd_data(rd_data)
  );
endmodule

// File: rtl/fpm_chk.sv
module fpm_chk #(
  parameter int MA_W     = 11,
  parameter int T_RCD    = 2,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int T_RASMAX = 10000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            oe_n,
  input logic            dq_oe,
  input logic [MA_W-1:0] addr,
  input logic            rd_valid,
  input logic            ref_gnt,
  input logic            req_ready
);
  localparam int CW = $clog2(T_RASMAX + T_RP + 2) + 1;
  localparam logic [CW-1:0] SAT = CW'(T_RASMAX + T_RP + 1);

  logic [CW-1:0] lowcnt, hicnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowcnt <= '0;
      hicnt  <= SAT;
    end else begin
      if (ras_n) lowcnt <= '0;
      else if (lowcnt < SAT) lowcnt <= lowcnt + 1'b1;
      if (!ras_n) hicnt <= '0;
      else if (hicnt < SAT) hicnt <= hicnt + 1'b1;
    end
  end

  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R4
  AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_n) |-> lowcnt >= CW'(T_RCD)); // R2
  AST_RAS_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> lowcnt >= CW'(T_RAS)); // R3
  AST_RP_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> hicnt >= CW'(T_RP)); // R3
  AST_RAS_MAX: assert property (@(posedge clk) disable iff (!rst_n) lowcnt <= CW'(T_RASMAX)); // R9
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cas_n && !$past(cas_n)) |-> ($stable(addr) && $stable(we_n))); // R1
  AST_BUS_DIR: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (oe_n && !we_n && !cas_n)); // R5
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R6
  AST_GNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ref_gnt |-> (ras_n && cas_n && !req_ready)); // R10
endmodule

bind fpm_dram_ctrl fpm_chk #(
  .MA_W(MA_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RASMAX(T_RASMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .addr(dram_addr), .rd_valid(rd_valid),
  .ref_gnt(ref_gnt), .req_ready(req_ready)
);

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_RAC = 5, T_CAC = 2, T_RAS = 5, T_RP = 3, T_CP = 1;
  localparam int RASMAX = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, dq_in = 8'hEE;
  logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [7:0]  rd_data, dq_out;
  logic [10:0] maddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_dram_ctrl #(.T_RASMAX(RASMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(maddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [21:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ {2'b0, a[21:16]} ^ 8'h5A;
  endfunction

  // ---------------- RAM model ----------------
  logic [7:0] dmem [logic [21:0]];
  logic [10:0] row_l, col_l;
  logic prev_ras = 1'b1, prev_cas = 1'b1, we_l = 1'b1;
  int ras_lc = 0, cas_lc = 0, hi_lc = 100, max_ras_lc = 0, ras_falls = 0;
  int v_r1 = 0, v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n) begin
        if (prev_ras) begin
          ras_falls++;
          row_l = maddr;
          if (hi_lc < T_RP) v_r3++;
        end
        ras_lc++; hi_lc = 0;
      end else begin
        if (!prev_ras && ras_lc < T_RAS) v_r3++;
        ras_lc = 0; hi_lc++;
      end
      if (ras_lc > max_ras_lc) max_ras_lc = ras_lc;
      if (!cas_n) begin
        if (ras_n) v_r4++;
        if (prev_cas) begin
          cas_lc = 1; col_l = maddr; we_l = we_n;
          if (ras_lc < T_RCD + 1) v_r2++;
          if (!we_n) begin
            if (!dq_oe || !oe_n) v_r5++;
            dmem[{row_l, col_l}] = dq_out;
          end else if (dq_oe || oe_n) v_r6++;
        end else begin
          cas_lc++;
          if (maddr != col_l || we_n != we_l) v_r1++;
        end
      end else cas_lc = 0;
      if (!cas_n && !oe_n && cas_lc >= T_CAC && ras_lc >= T_RAC)
        dq_in = dmem.exists({row_l, col_l}) ? dmem[{row_l, col_l}] : init_val({row_l, col_l});
      else dq_in = 8'hEE;
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  // ---------------- expected model and read monitor ----------------
  logic [7:0] emem [logic [21:0]];
  logic [7:0] expq [$];

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) chk(1'b0, "R6 unexpected rd_valid", 1, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R6 read data", rd_data, e);
      end
    end
  end

  task automatic send(input logic wr, input logic [21:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (wr) emem[a] = d;
    else expq.push_back(emem.exists(a) ? emem[a] : init_val(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (expq.size() != 0 || !ras_n); i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R11 strobes high", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(!dq_oe && !rd_valid, "R11 bus and rd_valid low", {dq_oe, rd_valid}, 0);
    chk(req_ready, "R11 ready after reset", req_ready, 1);

    // R5/R6/R1 single accesses, R12 ready low during cycle
    send(1'b1, 22'h12345, 8'hA5);
    #1 chk(!req_ready, "R12 ready low during cycle", req_ready, 0);
    send(1'b0, 22'h2ABCD, 8'h00);
    send(1'b0, 22'h12345, 8'h00);
    drain();
    chk(expq.size() == 0, "R6 all reads returned", expq.size(), 0);

    // R7 page hits
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) send(1'b1, {11'h155, 11'(i * 7)}, 8'(8'h30 + i));
    for (int i = 0; i < 4; i++) send(1'b0, {11'h155, 11'(i * 7)}, 8'h00);
    drain();
    chk(ras_falls - f0 == 1, "R7 one activation for same-row run", ras_falls - f0, 1);

    // R8 row misses
    f0 = ras_falls;
    send(1'b0, {11'h001, 11'h010}, 8'h00);
    send(1'b0, {11'h002, 11'h010}, 8'h00);
    send(1'b0, {11'h001, 11'h011}, 8'h00);
    drain();
    chk(ras_falls - f0 == 3, "R8 activation per row change", ras_falls - f0, 3);

    // R12 payload ignored while valid low
    f0 = ras_falls;
    req_write = 1'b1; req_addr = 22'h3F0F0; req_wdata = 8'hC3;
    for (int i = 0; i < 20; i++) begin @(negedge clk); req_wdata = 8'(i); end
    chk(ras_falls == f0, "R12 no cycle without valid", ras_falls - f0, 0);
    send(1'b0, 22'h3F0F0, 8'h00);
    drain();

    // R10 refresh during page burst
    f0 = ras_falls;
    fork
      begin
        for (int i = 0; i < 6; i++) send(1'b0, {11'h0AA, 11'(i)}, 8'h00);
      end
      begin
        int w;
        repeat (8) @(negedge clk);
        ref_req = 1'b1;
        w = 0;
        while (!ref_gnt && w < 50) begin @(negedge clk); w++; end
        chk(ref_gnt == 1'b1, "R10 grant reached", ref_gnt, 1);
        chk(ras_n && cas_n && !req_ready, "R10 idle under grant", {ras_n, cas_n, req_ready}, 3'b110);
        repeat (10) @(negedge clk);
        chk(ras_n && ref_gnt, "R10 stays idle while refresh", {ras_n, ref_gnt}, 2'b11);
        ref_req = 1'b0;
      end
    join
    drain();
    chk(ras_falls - f0 >= 2, "R10 page closed for refresh", ras_falls - f0, 2);

    // R9 RAS-low limit
    f0 = ras_falls; max_ras_lc = 0;
    for (int i = 0; i < 20; i++) send(1'b1, {11'h777, 11'(i)}, 8'(i * 3));
    for (int i = 0; i < 20; i++) send(1'b0, {11'h777, 11'(i)}, 8'h00);
    drain();
    chk(max_ras_lc <= RASMAX, "R9 RAS low bounded", max_ras_lc, RASMAX);
    chk(ras_falls - f0 >= 2, "R9 long run split", ras_falls - f0, 2);

    // random mix over four rows
    for (int i = 0; i < 400; i++) begin
      logic [21:0] a;
      logic wr;
      a = {9'h0, 2'($urandom), 11'($urandom % 16)};
      wr = 1'($urandom);
      send(wr, a, 8'($urandom));
      if (($urandom % 4) == 0) repeat (1 + $urandom % 5) @(negedge clk);
    end
    drain();
    chk(expq.size() == 0, "R6 random reads returned", expq.size(), 0);

    chk(v_r1 == 0, "R1 column/WE stable", v_r1, 0);
    chk(v_r2 == 0, "R2 RAS-to-CAS delay", v_r2, 0);
    chk(v_r3 == 0, "R3 RAS low/high widths", v_r3, 0);
    chk(v_r4 == 0, "R4 CAS only in row", v_r4, 0);
    chk(v_r5 == 0, "R5 early write bus control", v_r5, 0);
    chk(v_r6 == 0, "R6 read bus control", v_r6, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
  end
endmodule